// File: doc/BRIEF.md
# Snoop-Invalidate Coherence Controller

This controller sits beside an on-chip SRAM that a DMA engine writes into, and keeps that SRAM coherent with a two-way, write-back L1 data cache. It keeps a shadow copy of the L1 tag and valid state. The L1 sends it a notification each time it allocates or evicts a line, and the shadow copy is updated from these notifications. Every DMA word write is looked up in the shadow copy. A write to a line the L1 does not hold goes straight to the SRAM.

A write to a resident line causes a snoop-invalidate to be sent to the L1, and the DMA port stalls until the L1 answers. The answer carries a dirty flag and the line contents. If the line is dirty, the returned line is written to the SRAM first, and the DMA word is written after it, so the DMA data is the final value. A clean answer costs no write-back cycle. When the answer arrives, the shadow entry is cleared to mirror the L1 invalidation. Each DMA write also produces a plain invalidate for the same line towards the program cache. DMA reads of the SRAM do not pass through this block.

A probe port returns the current shadow residency of any line. This lets the L1 side, and the bench, see what the filter holds.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: While rst_n is low, and on its release, dma_wr_ready is 1 and sram_we, snp_req_valid and pinv_valid are 0. All shadow entries are invalid, so probe_hit reads 0 for every line.
- R2: A DMA write accepted (dma_wr_valid and dma_wr_ready both high at a clock edge) to a line not resident in the shadow copy produces an SRAM write in the next cycle. sram_line is the word address bits above the low four, which form the word index. sram_wdata carries the word at bit position 32 times the word index. sram_wstrb has exactly four ones, starting at bit 4 times the word index. No snoop is issued.
- R3: An allocate notification (line address, way) makes probe_hit read 1 for that line from the next cycle on. An evict notification (set, way) makes it read 0.
- R4: A DMA write that hits in the shadow copy raises snp_req_valid for one cycle, the cycle after acceptance, with snp_req_line equal to the written line address.
- R5: dma_wr_ready is 0 from the cycle after an acceptance until the SRAM write of the DMA word has taken place. During that time no SRAM write occurs while the block waits for the snoop answer.
- R6: A dirty snoop answer produces, in the next cycle, a full-line SRAM write (all 64 strobe bits set) of the returned line. The DMA word write follows in the cycle after that.
- R7: A clean snoop answer produces the DMA word write in the next cycle, with no write-back cycle.
- R8: From the cycle after the snoop answer, the snooped line reads probe_hit 0.
- R9: Every DMA write raises pinv_valid for exactly the cycle of its DMA-word SRAM write, with pinv_line equal to the written line. dma_wr_ready is 1 again in the following cycle.
- R10: Residency needs both a set valid bit and an equal tag. A write to a line whose set holds a different tag takes the direct path of R2.
- R11: The two ways of a set are independent. Evicting one way leaves the other way resident, and a write to the remaining line is still snooped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_wr_valid | input | 1 | DMA word write request |
| dma_wr_ready | output | 1 | Controller can accept a DMA write |
| dma_wr_addr | input | 18 | DMA word address |
| dma_wr_data | input | 32 | DMA write word |
| l1_alloc_valid | input | 1 | L1 allocated a line |
| l1_alloc_line | input | 14 | Line address of the allocation |
| l1_alloc_way | input | 1 | Way of the allocation |
| l1_evict_valid | input | 1 | L1 evicted a line |
| l1_evict_set | input | 7 | Set of the eviction |
| l1_evict_way | input | 1 | Way of the eviction |
| snp_req_valid | output | 1 | Snoop-invalidate request to the L1 data cache |
| snp_req_line | output | 14 | Line address being snooped |
| snp_ack_valid | input | 1 | Snoop answer from the L1 |
| snp_ack_dirty | input | 1 | Snooped line was modified |
| snp_ack_data | input | 512 | Contents of the snooped line |
| pinv_valid | output | 1 | Invalidate to the program cache |
| pinv_line | output | 14 | Line address for the program cache invalidate |
| sram_we | output | 1 | SRAM write enable |
| sram_line | output | 14 | SRAM line address |
| sram_wdata | output | 512 | SRAM write line data |
| sram_wstrb | output | 64 | SRAM byte strobes |
| probe_line | input | 14 | Line address to query in the shadow copy |
| probe_hit | output | 1 | Queried line is resident |

## Verification
The properties assume that the L1 sends a snoop answer only while the controller is waiting for one. They also assume that no allocate or evict notification touches a line while that line is being snooped. The bench keeps to this by raising snp_ack_valid for exactly one cycle, and only after it has seen snp_req_valid. It sends notifications only while the DMA port is idle. A DMA write request is held for a single accepted cycle, so every transaction is followed edge by edge along the expected path.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SNOOP  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_WBACK  = 3'd3,
    ST_COMMIT = 3'd4
  } coh_state_t;
endpackage

// File: rtl/coh_shadow_tags.sv
module coh_shadow_tags #(
  parameter int SET_W    = 7,
  parameter int TAG_W    = 7,
  parameter int NUM_WAYS = 2,
  parameter int WAY_W    = 1,
  localparam int NUM_SETS = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [SET_W-1:0] alloc_set,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [WAY_W-1:0] alloc_way,
  input  logic             evict_en,
  input  logic [SET_W-1:0] evict_set,
  input  logic [WAY_W-1:0] evict_way,
  input  logic             clear_en,
  input  logic [SET_W-1:0] clear_set,
  input  logic [WAY_W-1:0] clear_way,
  input  logic [SET_W-1:0] lookup_set,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic             lookup_hit,
  output logic [WAY_W-1:0] lookup_way,
  input  logic [SET_W-1:0] probe_set,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             probe_hit
);

  logic             valid_q [NUM_WAYS][NUM_SETS];
  logic             valid_d [NUM_WAYS][NUM_SETS];
  logic [TAG_W-1:0] tag_q   [NUM_WAYS][NUM_SETS];
  logic [NUM_WAYS-1:0] lk_way_hit;
  logic [NUM_WAYS-1:0] pr_way_hit;

  // next-state of the valid array: evictions and snoop clears first,
  // an allocation in the same cycle wins
  always_comb begin
    valid_d = valid_q;
    if (evict_en) valid_d[evict_way][evict_set] = 1'b0;
    if (clear_en) valid_d[clear_way][clear_set] = 1'b0;
    if (alloc_en) valid_d[alloc_way][alloc_set] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WAYS; w++)
        for (int s = 0; s < NUM_SETS; s++)
          valid_q[w][s] <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[alloc_way][alloc_set] <= alloc_tag;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way_cmp
    assign lk_way_hit[w] = valid_q[w][lookup_set] && (tag_q[w][lookup_set] == lookup_tag);
    assign pr_way_hit[w] = valid_q[w][probe_set]  && (tag_q[w][probe_set]  == probe_tag);
  end

  always_comb begin
    lookup_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (lk_way_hit[w]) lookup_way = WAY_W'(w);
  end

  assign lookup_hit = |lk_way_hit;
  assign probe_hit  = |pr_way_hit;

endmodule

// File: rtl/coh_line_pack.sv
module coh_line_pack #(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int WORD_W  = WORD_BYTES * 8,
  localparam int NWORDS  = LINE_BYTES / WORD_BYTES,
  localparam int WIDX_W  = $clog2(NWORDS)
) (
  input  logic [WORD_W-1:0]     word_data,
  input  logic [WIDX_W-1:0]     word_idx,
  input  logic [LINE_W-1:0]     wb_line,
  input  logic                  wb_sel,
  output logic [LINE_W-1:0]     line_data,
  output logic [LINE_BYTES-1:0] line_strb
);

  for (genvar w = 0; w < NWORDS; w++) begin : g_lane
    logic lane_on;
    assign lane_on = (word_idx == WIDX_W'(w));
    assign line_data[w*WORD_W +: WORD_W] =
      wb_sel ? wb_line[w*WORD_W +: WORD_W] : word_data;
    assign line_strb[w*WORD_BYTES +: WORD_BYTES] =
      {WORD_BYTES{wb_sel | lane_on}};
  end

endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
  import coh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_wr_valid,
  input  logic lookup_hit,
  input  logic snp_ack_valid,
  input  logic snp_ack_dirty,
  output logic dma_wr_ready,
  output logic capture_en,
  output logic snp_req,
  output logic clear_en,
  output logic wb_load_en,
  output logic wb_write,
  output logic commit_write,
  output logic waiting
);

  coh_state_t state_q, state_d;

  always_comb begin
    state_d      = state_q;
    dma_wr_ready = 1'b0;
    capture_en   = 1'b0;
    snp_req      = 1'b0;
    clear_en     = 1'b0;
    wb_load_en   = 1'b0;
    wb_write     = 1'b0;
    commit_write = 1'b0;
    case (state_q)
      ST_IDLE: begin
        dma_wr_ready = 1'b1;
        if (dma_wr_valid) begin
          capture_en = 1'b1;
          state_d    = lookup_hit ? ST_SNOOP : ST_COMMIT;
        end
      end
      ST_SNOOP: begin
        snp_req = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (snp_ack_valid) begin
          clear_en = 1'b1;
          if (snp_ack_dirty) begin
            wb_load_en = 1'b1;
            state_d    = ST_WBACK;
          end else begin
            state_d    = ST_COMMIT;
          end
        end
      end
      ST_WBACK: begin
        wb_write = 1'b1;
        state_d  = ST_COMMIT;
      end
      ST_COMMIT: begin
        commit_write = 1'b1;
        state_d      = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign waiting = (state_q == ST_WAIT);

endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  parameter int NUM_SETS   = 128,
  parameter int NUM_WAYS   = 2,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int WB_W    = $clog2(WORD_BYTES),
  localparam int WADDR_W = ADDR_W - WB_W,
  localparam int WIDX_W  = OFF_W - WB_W,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int WORD_W  = WORD_BYTES * 8,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dma_wr_valid,
  output logic                  dma_wr_ready,
  input  logic [WADDR_W-1:0]    dma_wr_addr,
  input  logic [WORD_W-1:0]     dma_wr_data,
  input  logic                  l1_alloc_valid,
  input  logic [LADDR_W-1:0]    l1_alloc_line,
  input  logic [WAY_W-1:0]      l1_alloc_way,
  input  logic                  l1_evict_valid,
  input  logic [SET_W-1:0]      l1_evict_set,
  input  logic [WAY_W-1:0]      l1_evict_way,
  output logic                  snp_req_valid,
  output logic [LADDR_W-1:0]    snp_req_line,
  input  logic                  snp_ack_valid,
  input  logic                  snp_ack_dirty,
  input  logic [LINE_W-1:0]     snp_ack_data,
  output logic                  pinv_valid,
  output logic [LADDR_W-1:0]    pinv_line,
  output logic                  sram_we,
  output logic [LADDR_W-1:0]    sram_line,
  output logic [LINE_W-1:0]     sram_wdata,
  output logic [LINE_BYTES-1:0] sram_wstrb,
  input  logic [LADDR_W-1:0]    probe_line,
  output logic                  probe_hit
);

  logic               capture_en, snp_req, clear_en, wb_load_en;
  logic               wb_write, commit_write, snoop_waiting;
  logic               lookup_hit;
  logic [WAY_W-1:0]   lookup_way;

  logic [WADDR_W-1:0] req_addr_q, req_addr_d;
  logic [WORD_W-1:0]  req_data_q, req_data_d;
  logic [WAY_W-1:0]   req_way_q,  req_way_d;
  logic [LINE_W-1:0]  wb_data_q,  wb_data_d;

  logic [LADDR_W-1:0] req_line;
  logic [WIDX_W-1:0]  req_widx;
  logic [LADDR_W-1:0] in_line;

  assign in_line  = dma_wr_addr[WADDR_W-1:WIDX_W];
  assign req_line = req_addr_q[WADDR_W-1:WIDX_W];
  assign req_widx = req_addr_q[WIDX_W-1:0];

  coh_shadow_tags #(
    .SET_W(SET_W), .TAG_W(TAG_W), .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (l1_alloc_valid),
    .alloc_set  (l1_alloc_line[SET_W-1:0]),
    .alloc_tag  (l1_alloc_line[LADDR_W-1:SET_W]),
    .alloc_way  (l1_alloc_way),
    .evict_en   (l1_evict_valid),
    .evict_set  (l1_evict_set),
    .evict_way  (l1_evict_way),
    .clear_en   (clear_en),
    .clear_set  (req_line[SET_W-1:0]),
    .clear_way  (req_way_q),
    .lookup_set (in_line[SET_W-1:0]),
    .lookup_tag (in_line[LADDR_W-1:SET_W]),
    .lookup_hit (lookup_hit),
    .lookup_way (lookup_way),
    .probe_set  (probe_line[SET_W-1:0]),
    .probe_tag  (probe_line[LADDR_W-1:SET_W]),
    .probe_hit  (probe_hit)
  );

  coh_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_wr_valid (dma_wr_valid),
    .lookup_hit   (lookup_hit),
    .snp_ack_valid(snp_ack_valid),
    .snp_ack_dirty(snp_ack_dirty),
    .dma_wr_ready (dma_wr_ready),
    .capture_en   (capture_en),
    .snp_req      (snp_req),
    .clear_en     (clear_en),
    .wb_load_en   (wb_load_en),
    .wb_write     (wb_write),
    .commit_write (commit_write),
    .waiting      (snoop_waiting)
  );

  // request and write-back holding registers, clock enables written out
  always_comb begin
    req_addr_d = req_addr_q;
    req_data_d = req_data_q;
    req_way_d  = req_way_q;
    wb_data_d  = wb_data_q;
    if (capture_en) begin
      req_addr_d = dma_wr_addr;
      req_data_d = dma_wr_data;
      req_way_d  = lookup_way;
    end
    if (wb_load_en) wb_data_d = snp_ack_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q <= '0;
      req_data_q <= '0;
      req_way_q  <= '0;
    end else begin
      req_addr_q <= req_addr_d;
      req_data_q <= req_data_d;
      req_way_q  <= req_way_d;
    end
  end

  always_ff @(posedge clk) begin
    wb_data_q <= wb_data_d;
  end

  coh_line_pack #(
    .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_pack (
    .word_data (req_data_q),
    .word_idx  (req_widx),
    .wb_line   (wb_data_q),
    .wb_sel    (wb_write),
    .line_data (sram_wdata),
    .line_strb (sram_wstrb)
  );

  assign sram_we       = wb_write | commit_write;
  assign sram_line     = req_line;
  assign snp_req_valid = snp_req;
  assign snp_req_line  = req_line;
  assign pinv_valid    = commit_write;
  assign pinv_line     = req_line;

endmodule

// File: rtl/snoop_coherence_ctrl_sva.sv
module snoop_coherence_ctrl_sva #(
  parameter int LINE_BYTES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dma_wr_valid,
  input logic                  dma_wr_ready,
  input logic                  sram_we,
  input logic [LINE_BYTES-1:0] sram_wstrb,
  input logic                  snp_req_valid,
  input logic                  snp_ack_valid,
  input logic                  snp_ack_dirty,
  input logic                  pinv_valid,
  input logic                  snoop_waiting
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (dma_wr_ready && !sram_we && !snp_req_valid && !pinv_valid)
        else $error("reset outputs not idle");
    end
  end

  assert_accept_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr_valid && dma_wr_ready) |=> !dma_wr_ready);

  assert_snoop_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_req_valid |-> !dma_wr_ready);

  assert_wait_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_waiting |-> (!sram_we && !dma_wr_ready));

  assert_snoop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snp_req_valid |=> (snoop_waiting && !snp_req_valid));

  assert_dirty_wb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_waiting && snp_ack_valid && snp_ack_dirty) |=> (sram_we && !pinv_valid && (&sram_wstrb)));

  assert_wb_then_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && !pinv_valid) |=> (sram_we && pinv_valid));

  assert_clean_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_waiting && snp_ack_valid && !snp_ack_dirty) |=> (sram_we && pinv_valid));

  assert_commit_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pinv_valid |=> (dma_wr_ready && !pinv_valid));

endmodule

bind snoop_coherence_ctrl snoop_coherence_ctrl_sva #(.LINE_BYTES(LINE_BYTES)) u_sva (.*);

// File: tb/snoop_coherence_ctrl_test.sv
`timescale 1ns/1ps
module snoop_coherence_ctrl_test;

  localparam int LINE_W = 512;

  logic          clk, rst_n;
  logic          dma_wr_valid, dma_wr_ready;
  logic [17:0]   dma_wr_addr;
  logic [31:0]   dma_wr_data;
  logic          l1_alloc_valid;
  logic [13:0]   l1_alloc_line;
  logic          l1_alloc_way;
  logic          l1_evict_valid;
  logic [6:0]    l1_evict_set;
  logic          l1_evict_way;
  logic          snp_req_valid;
  logic [13:0]   snp_req_line;
  logic          snp_ack_valid, snp_ack_dirty;
  logic [511:0]  snp_ack_data;
  logic          pinv_valid;
  logic [13:0]   pinv_line;
  logic          sram_we;
  logic [13:0]   sram_line;
  logic [511:0]  sram_wdata;
  logic [63:0]   sram_wstrb;
  logic [13:0]   probe_line;
  logic          probe_hit;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  logic [511:0] model_mem [int];

  snoop_coherence_ctrl uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // SRAM model
  always @(posedge clk) begin
    if (rst_n && sram_we) begin
      logic [511:0] cur;
      cur = model_mem.exists(int'(sram_line)) ? model_mem[int'(sram_line)] : '0;
      for (int b = 0; b < 64; b++)
        if (sram_wstrb[b]) cur[b*8 +: 8] = sram_wdata[b*8 +: 8];
      model_mem[int'(sram_line)] = cur;
    end
  end

  task automatic chk(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk_line(input int tag, input int set);
    return 14'((tag << 7) | set);
  endfunction

  function automatic logic [511:0] lane(input int idx, input logic [31:0] d);
    return 512'(d) << (idx * 32);
  endfunction

  function automatic logic [63:0] lstrb(input int idx);
    return 64'hF << (idx * 4);
  endfunction

  function automatic logic [511:0] mem_rd(input logic [13:0] l);
    return model_mem.exists(int'(l)) ? model_mem[int'(l)] : '0;
  endfunction

  task automatic probe(input logic [13:0] l, input logic exp, input string req);
    probe_line = l;
    #0.5;
    chk(req, LINE_W'(probe_hit), LINE_W'(exp));
  endtask

  task automatic alloc(input logic [13:0] l, input logic way);
    @(negedge clk);
    l1_alloc_valid = 1'b1; l1_alloc_line = l; l1_alloc_way = way;
    @(posedge clk);
    @(negedge clk);
    l1_alloc_valid = 1'b0;
  endtask

  task automatic evict(input logic [6:0] set, input logic way);
    @(negedge clk);
    l1_evict_valid = 1'b1; l1_evict_set = set; l1_evict_way = way;
    @(posedge clk);
    @(negedge clk);
    l1_evict_valid = 1'b0;
  endtask

  // drive one DMA write; returns at the negedge after acceptance
  task automatic dma_issue(input logic [13:0] l, input int idx, input logic [31:0] d);
    @(negedge clk);
    dma_wr_valid = 1'b1; dma_wr_addr = {l, 4'(idx)}; dma_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    dma_wr_valid = 1'b0;
  endtask

  task automatic expect_commit(input logic [13:0] l, input int idx, input logic [31:0] d, input string req);
    chk({req, " we"},    LINE_W'(sram_we), 1);
    chk({req, " line"},  LINE_W'(sram_line), LINE_W'(l));
    chk({req, " strb"},  LINE_W'(sram_wstrb), LINE_W'(lstrb(idx)));
    chk({req, " lane"},  LINE_W'(sram_wdata[idx*32 +: 32]), LINE_W'(d));
    chk("R9 pinv",       LINE_W'({pinv_valid, pinv_line}), LINE_W'({1'b1, l}));
  endtask

  task automatic snoop_answer(input logic dirty, input logic [511:0] data);
    @(posedge clk);
    @(negedge clk);
    snp_ack_valid = 1'b1; snp_ack_dirty = dirty; snp_ack_data = data;
    @(posedge clk);
    @(negedge clk);
    snp_ack_valid = 1'b0; snp_ack_dirty = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready", LINE_W'(dma_wr_ready), 1);
    chk("R1 quiet", LINE_W'({sram_we, snp_req_valid, pinv_valid}), 0);
    probe(mk_line(3, 9), 1'b0, "R1 probe");
  endtask

  task automatic t_miss;
    logic [13:0] l;
    l = mk_line(0, 5);
    dma_issue(l, 3, 32'hA5A5_0003);
    chk("R2 no snoop", LINE_W'(snp_req_valid), 0);
    expect_commit(l, 3, 32'hA5A5_0003, "R2");
    @(negedge clk);
    chk("R9 ready back", LINE_W'(dma_wr_ready), 1);
    chk("R2 sram", mem_rd(l), lane(3, 32'hA5A5_0003));
  endtask

  task automatic t_alloc_tag;
    alloc(mk_line(3, 9), 1'b0);
    probe(mk_line(3, 9), 1'b1, "R3 alloc");
    probe(mk_line(4, 9), 1'b0, "R10 tag mismatch probe");
    dma_issue(mk_line(4, 9), 1, 32'h4444_0001);
    chk("R10 no snoop", LINE_W'(snp_req_valid), 0);
    expect_commit(mk_line(4, 9), 1, 32'h4444_0001, "R10");
  endtask

  task automatic t_clean_hit;
    logic [13:0] l;
    l = mk_line(3, 9);
    dma_issue(l, 0, 32'hC1EA_0000);
    chk("R4 snoop", LINE_W'({snp_req_valid, snp_req_line}), LINE_W'({1'b1, l}));
    chk("R5 stall", LINE_W'(dma_wr_ready), 0);
    // hold off the answer for a few cycles
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 wait", LINE_W'({dma_wr_ready, sram_we, snp_req_valid}), 0);
    end
    snoop_answer(1'b0, '1);
    expect_commit(l, 0, 32'hC1EA_0000, "R7");
    probe(l, 1'b0, "R8 clean cleared");
    @(negedge clk);
    chk("R7 sram", mem_rd(l), lane(0, 32'hC1EA_0000));
  endtask

  task automatic t_dirty_hit;
    logic [13:0]  l;
    logic [511:0] pat, exp;
    l = mk_line(5, 20);
    for (int i = 0; i < 16; i++) pat[i*32 +: 32] = 32'hD000_0000 | i;
    alloc(l, 1'b1);
    dma_issue(l, 7, 32'h0BAD_F00D);
    chk("R4 snoop", LINE_W'({snp_req_valid, snp_req_line}), LINE_W'({1'b1, l}));
    snoop_answer(1'b1, pat);
    chk("R6 wb we",   LINE_W'({sram_we, pinv_valid, dma_wr_ready}), LINE_W'(3'b100));
    chk("R6 wb strb", LINE_W'(sram_wstrb), LINE_W'({64{1'b1}}));
    chk("R6 wb data", sram_wdata, pat);
    chk("R6 wb line", LINE_W'(sram_line), LINE_W'(l));
    probe(l, 1'b0, "R8 dirty cleared");
    @(negedge clk);
    expect_commit(l, 7, 32'h0BAD_F00D, "R6");
    @(negedge clk);
    exp = pat;
    exp[7*32 +: 32] = 32'h0BAD_F00D;
    chk("R6 final sram", mem_rd(l), exp);
    chk("R9 ready back", LINE_W'(dma_wr_ready), 1);
    probe(l, 1'b0, "R8 shadow valid 0");
  endtask

  task automatic t_two_ways;
    alloc(mk_line(6, 30), 1'b0);
    alloc(mk_line(7, 30), 1'b1);
    probe(mk_line(6, 30), 1'b1, "R11 way0");
    probe(mk_line(7, 30), 1'b1, "R11 way1");
    evict(7'd30, 1'b0);
    probe(mk_line(6, 30), 1'b0, "R3 evict");
    probe(mk_line(7, 30), 1'b1, "R11 way1 kept");
    dma_issue(mk_line(6, 30), 2, 32'h6666_0002);
    chk("R11 evicted no snoop", LINE_W'(snp_req_valid), 0);
    @(negedge clk);
    dma_issue(mk_line(7, 30), 2, 32'h7777_0002);
    chk("R11 snoop way1", LINE_W'({snp_req_valid, snp_req_line}), LINE_W'({1'b1, mk_line(7, 30)}));
    snoop_answer(1'b0, '0);
    expect_commit(mk_line(7, 30), 2, 32'h7777_0002, "R11");
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    dma_wr_valid = 1'b0; dma_wr_addr = '0; dma_wr_data = '0;
    l1_alloc_valid = 1'b0; l1_alloc_line = '0; l1_alloc_way = 1'b0;
    l1_evict_valid = 1'b0; l1_evict_set = '0; l1_evict_way = 1'b0;
    snp_ack_valid = 1'b0; snp_ack_dirty = 1'b0; snp_ack_data = '0;
    probe_line = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_miss;
    t_alloc_tag;
    t_clean_hit;
    t_dirty_hit;
    t_two_ways;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule